// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Summary

This block is a memory-mapped bank of general-purpose pins. Every pin owns one 32-bit word that holds its output drive, a read-only view of its synchronized input level, its interrupt detection settings and its sticky interrupt status. Detection can be level-sensitive (active high or active low) or edge-sensitive (rising, falling or both). A separate enable starts detection, and a delivery bit decides whether a recorded status reaches the interrupt path.

Pending interrupts are condensed into a 64-bit summary, one bit per group of four pins, that software reads from two words to find the groups worth visiting. One host interrupt line is driven while any delivered status is set. After servicing the pins, software writes an end-of-interrupt bit in a master word. This forces the line low for one cycle, and the line then reflects the pending state again.

The host port is a plain register port, not a stream. A write takes effect on the clock edge where `bus_wr` is high. A read request on one edge returns its data with `bus_rvalid` on the next edge. The port never stalls, so it needs no back-pressure. The pin count `NUM_PINS` may range from 64 to 190. The word at byte offset 0xFC belongs to the master register, so pin 63 has no usable register.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin word reads 0 apart from the input level in bit 16, `pin_oe` and `pin_out` are all 0, and `host_irq` is 0.
- R2: Pin p's word sits at byte address 4·p. Only bits 8–12, 22 and 23 are writable. Writes to bit 16 and to every other bit have no effect. A read request returns the word on the next clock edge with `bus_rvalid` high.
- R3: `pin_oe[p]` equals bit 23 of pin p's word. `pin_out[p]` equals bit 22 when bit 23 is 1 and is 0 otherwise.
- R4: Bit 16 shows the pin input after a two-flop synchronizer. A change at the input is visible in a read issued two clock edges later.
- R5: With bit 8 = 0 (edge mode) and bit 11 = 1, status bit 28 is set by a rising input when bit 9 = 0 and bit 10 = 0, by a falling input when bit 9 = 1 and bit 10 = 0, and by either transition when bit 10 = 1.
- R6: With bit 8 = 1 (level mode) and bit 11 = 1, status is set while the input is at its active level: high when bit 9 = 0, low when bit 9 = 1. A clearing write makes the status read 0 for one cycle. If the input is still active, the status sets again on the next edge.
- R7: Writing a word with bit 28 = 1 clears that pin's status. If an edge event arrives in the same cycle as that write, the edge event wins and the status stays set.
- R8: With bit 11 = 0, no new status is recorded. With bit 12 = 0, a recorded status stays out of the summary and out of `host_irq`.
- R9: The summary is read at 0x2F8 (bits 31:0) and 0x2FC (bits 63:32). Bit i is 1 when any of pins 4i..4i+3 has status 1 together with bit 12 = 1. Writes to these two addresses are ignored.
- R10: `host_irq` goes to 1 one edge after any delivered status exists. A write to 0xFC with bit 29 = 1 forces it to 0 on the next edge, and it re-evaluates one edge after that. Reads of 0xFC return 0.
- R11: Writes to 0xFC never reach pin 63, so pin 63 never drives and never raises an interrupt. Addresses that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read request for one cycle |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin output enables |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
Two pairs of events can land in the same cycle. In the first, an edge event and a status-clearing write hit the same pin together. The bench raises a pin input, waits exactly two edges for the synchronizer, and then issues the acknowledge write. A following read must still show status 1 (R7). In the second, the end-of-interrupt write arrives while a delivered status is still pending. The bench samples `host_irq` on the two following cycles and expects 0 and then 1 (R10). A behavioural reference model runs beside the design and checks the interrupt line, the pin outputs and every read reply on every cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int B_LEVEL   = 8;
  localparam int B_ACTLO   = 9;
  localparam int B_BOTH    = 10;
  localparam int B_DET_EN  = 11;
  localparam int B_DELIVER = 12;
  localparam int B_LVL_IN  = 16;
  localparam int B_OVAL    = 22;
  localparam int B_OEN     = 23;
  localparam int B_STS     = 28;
  localparam int B_EOI     = 29;

  localparam logic [11:0] A_MASTER = 12'h0FC;
  localparam logic [11:0] A_SUM_LO = 12'h2F8;
  localparam logic [11:0] A_SUM_HI = 12'h2FC;

  typedef struct packed {
    logic oen;
    logic oval;
    logic deliver;
    logic det_en;
    logic both;
    logic act_low;
    logic level;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_raw,
  input  logic     wr_en,
  input  pin_cfg_t wr_cfg,
  input  logic     wr_ack,
  output pin_cfg_t cfg,
  output logic     sts,
  output logic     lvl
);
  logic prev;
  logic lvl_active, edge_hit, level_hit, edge_evt, ack;

  gpio_sync2 #(.W(1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_raw),
    .q    (lvl)
  );

  always_comb begin
    lvl_active = cfg.act_low ? ~lvl : lvl;
    if (cfg.both)         edge_hit = lvl ^ prev;
    else if (cfg.act_low) edge_hit = prev & ~lvl;
    else                  edge_hit = lvl & ~prev;
    level_hit = cfg.det_en & cfg.level & lvl_active;
    edge_evt  = cfg.det_en & ~cfg.level & edge_hit;
    ack       = wr_en & wr_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      cfg  <= '0;
      sts  <= 1'b0;
    end else begin
      prev <= lvl;
      // an edge arriving with the acknowledge is kept; a level hit is not
      sts  <= edge_evt | ((sts | level_hit) & ~ack);
      if (wr_en) cfg <= wr_cfg;
    end
  end
endmodule

// File: rtl/gpio_irq_gate.sv
module gpio_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic eoi,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (eoi) irq <= 1'b0;
    else          irq <= pending;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 184,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                host_irq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SUM_W = 64;

  logic [IDX_W-1:0]    pin_idx;
  logic                is_master, is_sum_lo, is_sum_hi, eoi;
  pin_cfg_t            wr_cfg;
  logic [NUM_PINS-1:0] pin_wr, deliv;
  logic [31:0]         pin_word [NUM_PINS];
  logic [SUM_W-1:0]    summary;
  logic [31:0]         rd_pin, rd_mux;
  logic                unused_bits;

  assign pin_idx   = bus_addr[ADDR_W-1:2];
  assign is_master = (bus_addr == ADDR_W'(A_MASTER));
  assign is_sum_lo = (bus_addr == ADDR_W'(A_SUM_LO));
  assign is_sum_hi = (bus_addr == ADDR_W'(A_SUM_HI));
  assign eoi       = bus_wr & is_master & bus_wdata[B_EOI];
  assign unused_bits = ^{bus_wdata, bus_addr[1:0]};

  assign wr_cfg = '{oen:     bus_wdata[B_OEN],
                    oval:    bus_wdata[B_OVAL],
                    deliver: bus_wdata[B_DELIVER],
                    det_en:  bus_wdata[B_DET_EN],
                    both:    bus_wdata[B_BOTH],
                    act_low: bus_wdata[B_ACTLO],
                    level:   bus_wdata[B_LEVEL]};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [IDX_W-1:0] P_IDX = IDX_W'(p);
    pin_cfg_t cfg;
    logic     sts, lvl;

    // the master word shadows pin 63, so that pin can never be written
    assign pin_wr[p] = bus_wr & ~is_master & (pin_idx == P_IDX);

    gpio_pin_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_raw(pin_in[p]),
      .wr_en  (pin_wr[p]),
      .wr_cfg (wr_cfg),
      .wr_ack (bus_wdata[B_STS]),
      .cfg    (cfg),
      .sts    (sts),
      .lvl    (lvl)
    );

    assign pin_oe[p]  = cfg.oen;
    assign pin_out[p] = cfg.oen & cfg.oval;
    assign deliv[p]   = sts & cfg.deliver;
    assign pin_word[p] = {3'b0, sts, 4'b0, cfg.oen, cfg.oval, 5'b0, lvl, 3'b0,
                          cfg.deliver, cfg.det_en, cfg.both, cfg.act_low,
                          cfg.level, 8'b0};
  end

  for (genvar g = 0; g < SUM_W; g++) begin : g_sum
    if (4 * g < NUM_PINS) begin : g_used
      localparam int LO = 4 * g;
      localparam int HI = (4 * g + 3 < NUM_PINS) ? 4 * g + 3 : NUM_PINS - 1;
      assign summary[g] = |deliv[HI:LO];
    end else begin : g_none
      assign summary[g] = 1'b0;
    end
  end

  gpio_irq_gate u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .pending(|summary),
    .eoi    (eoi),
    .irq    (host_irq)
  );

  always_comb begin
    rd_pin = '0;
    for (int p = 0; p < NUM_PINS; p++)
      if (int'(pin_idx) == p) rd_pin = pin_word[p];
    if (is_master)      rd_mux = '0;
    else if (is_sum_lo) rd_mux = summary[31:0];
    else if (is_sum_hi) rd_mux = summary[63:32];
    else                rd_mux = rd_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NUM_PINS = 184,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                eoi_bit,
  input logic                bus_rvalid,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                host_irq,
  input logic [63:0]         summary
);
  logic master_hit;
  assign master_hit = bus_wr && (bus_addr == ADDR_W'(12'h0FC));

  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R2

  AST_EOI_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_hit && eoi_bit) |=> !host_irq); // R10

  AST_LINE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(summary != 64'd0)); // R10

  AST_MASTER_SPARES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    master_hit |=> $stable(pin_oe)); // R11
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .eoi_bit   (bus_wdata[29]),
  .bus_rvalid(bus_rvalid),
  .pin_oe    (pin_oe),
  .host_irq  (host_irq),
  .summary   (summary)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int NP = 184;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          host_irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .host_irq(host_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam logic [31:0] WMASK = 32'h00C0_1F00;
  logic [31:0] m_cfg [NP];
  logic        m_sts [NP];
  logic        h1 [NP], h2 [NP], h3 [NP];
  logic        m_irq, m_rvalid;
  logic [31:0] m_rdata;

  function automatic logic [63:0] m_summary();
    logic [63:0] s = '0;
    for (int p = 0; p < NP; p++)
      if (m_sts[p] && m_cfg[p][12]) s[p/4] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] m_word(input logic [11:0] a);
    logic [63:0] s = m_summary();
    int idx = int'(a[11:2]);
    if (a == 12'h0FC) return 32'h0;
    if (a == 12'h2F8) return s[31:0];
    if (a == 12'h2FC) return s[63:32];
    if (idx < NP) return m_cfg[idx] | (32'(h2[idx]) << 16) | (32'(m_sts[idx]) << 28);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_cfg[p] = '0; m_sts[p] = 0; h1[p] = 0; h2[p] = 0; h3[p] = 0;
      end
      m_irq = 0; m_rvalid = 0; m_rdata = '0;
    end else begin
      logic eoi;
      logic any;
      any = (m_summary() != 64'd0);
      eoi = bus_wr && bus_addr == 12'h0FC && bus_wdata[29];
      if (bus_rd) m_rdata = m_word(bus_addr);
      m_rvalid = bus_rd;
      m_irq = eoi ? 1'b0 : any;
      for (int p = 0; p < NP; p++) begin
        logic hit_lvl, hit_edge, on, rise, fall, wr_p;
        rise = h2[p] && !h3[p];
        fall = !h2[p] && h3[p];
        on   = m_cfg[p][9] ? !h2[p] : h2[p];
        hit_lvl = 0; hit_edge = 0;
        if (m_cfg[p][11]) begin
          if (m_cfg[p][8]) hit_lvl = on;
          else if (m_cfg[p][10]) hit_edge = rise || fall;
          else hit_edge = m_cfg[p][9] ? fall : rise;
        end
        wr_p = bus_wr && bus_addr != 12'h0FC && int'(bus_addr[11:2]) == p;
        m_sts[p] = hit_edge || ((m_sts[p] || hit_lvl) && !(wr_p && bus_wdata[28]));
        if (wr_p) m_cfg[p] = bus_wdata & WMASK;
        h3[p] = h2[p]; h2[p] = h1[p]; h1[p] = pin_in[p];
      end
    end
  end

  // compared on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NP-1:0] eoe, eout;
      for (int p = 0; p < NP; p++) begin
        eoe[p]  = m_cfg[p][23];
        eout[p] = m_cfg[p][23] & m_cfg[p][22];
      end
      check("R10 host_irq vs model", 32'(host_irq), 32'(m_irq));
      check("R3 pin_oe vs model", 32'(pin_oe != eoe), 32'd0);
      check("R3 pin_out vs model", 32'(pin_out != eout), 32'd0);
      check("R2 rvalid vs model", 32'(bus_rvalid), 32'(m_rvalid));
      if (m_rvalid) check("R2 read data vs model", bus_rdata, m_rdata);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(5);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(12'h000, d); check("R1 pin0 word after reset", d, 32'h0);
    check("R1 oe after reset", 32'(pin_oe != '0), 32'd0);
    check("R1 irq after reset", 32'(host_irq), 32'd0);

    // R2 / R3 writable fields and output drive on pin 5
    wr(12'h014, 32'h07C1_E0FF);
    rd(12'h014, d); check("R2 only writable bits kept", d, 32'h00C0_0000);
    check("R3 oe follows bit23", 32'(pin_oe[5]), 32'd1);
    check("R3 out follows bit22", 32'(pin_out[5]), 32'd1);
    wr(12'h014, 32'h0080_0000);
    check("R3 out low with bit22 clear", 32'(pin_out[5]), 32'd0);
    wr(12'h014, 32'h0040_0000);
    check("R3 out gated by oe", 32'(pin_out[5]), 32'd0);

    // R4 synchronized input level on pin 7
    pin_in[7] = 1'b1; idle(3);
    rd(12'h01C, d); check("R4 input level bit16", d, 32'h0001_0000);

    // R5 rising edge on pin 8, R9 summary, R7 clear
    wr(12'h020, 32'h0000_1800);
    pin_in[8] = 1'b1; idle(4);
    rd(12'h020, d); check("R5 rising edge sets status", d, 32'h1001_1800);
    check("R10 irq raised", 32'(host_irq), 32'd1);
    rd(12'h2F8, d); check("R9 summary low group 2", d, 32'h0000_0004);
    wr(12'h020, 32'h1000_1800); idle(2);
    rd(12'h020, d); check("R7 write-one clears status", d, 32'h0001_1800);
    check("R10 irq falls with no pending", 32'(host_irq), 32'd0);

    // R5 falling edge on pin 9
    wr(12'h024, 32'h0000_1A00);
    pin_in[9] = 1'b1; idle(4);
    rd(12'h024, d); check("R5 falling mode ignores rise", d, 32'h0001_1A00);
    pin_in[9] = 1'b0; idle(4);
    rd(12'h024, d); check("R5 falling edge sets status", d, 32'h1000_1A00);
    wr(12'h024, 32'h1000_1A00);

    // R5 both edges on pin 10
    wr(12'h028, 32'h0000_1C00);
    pin_in[10] = 1'b1; idle(4);
    rd(12'h028, d); check("R5 both-edge rise", d, 32'h1001_1C00);
    wr(12'h028, 32'h1000_1C00);
    pin_in[10] = 1'b0; idle(4);
    rd(12'h028, d); check("R5 both-edge fall", d, 32'h1000_1C00);
    wr(12'h028, 32'h1000_1C00);

    // R6 level mode on pin 12 (active high) and pin 13 (active low)
    wr(12'h030, 32'h0000_1900);
    pin_in[12] = 1'b1; idle(4);
    rd(12'h030, d); check("R6 level high sets status", d, 32'h1001_1900);
    wr(12'h030, 32'h1000_1900);
    rd(12'h030, d); check("R6 status reads 0 right after clear", d, 32'h0001_1900);
    rd(12'h030, d); check("R6 level re-asserts next cycle", d, 32'h1001_1900);
    pin_in[12] = 1'b0; idle(4);
    wr(12'h030, 32'h1000_1900); idle(2);
    rd(12'h030, d); check("R6 inactive level stays clear", d, 32'h0000_1900);
    wr(12'h034, 32'h0000_1B00); idle(4);
    rd(12'h034, d); check("R6 active-low level", d, 32'h1000_1B00);
    pin_in[13] = 1'b1; idle(4);
    wr(12'h034, 32'h1000_1B00); idle(2);
    rd(12'h034, d); check("R6 active-low released", d, 32'h0001_1B00);

    // R8 enable and delivery on pins 16 and 17
    wr(12'h040, 32'h0000_0800);
    pin_in[16] = 1'b1; idle(4);
    rd(12'h040, d); check("R8 status recorded without delivery", d, 32'h1001_0800);
    rd(12'h2F8, d); check("R8 undelivered kept out of summary", d, 32'h0);
    check("R8 undelivered keeps irq low", 32'(host_irq), 32'd0);
    wr(12'h044, 32'h0000_1000);
    pin_in[17] = 1'b1; idle(4);
    rd(12'h044, d); check("R8 detection disabled", d, 32'h0001_1000);
    wr(12'h040, 32'h0000_1800); idle(2);
    rd(12'h2F8, d); check("R9 delivery exposes group 4", d, 32'h0000_0010);
    wr(12'h040, 32'h1000_0000);
    pin_in[16] = 1'b0; idle(3); pin_in[16] = 1'b1; idle(6);
    rd(12'h040, d); check("R8 cleared enables stop interrupts", d, 32'h0001_0000);

    // R9 high summary word and read-only summary, pin 180 -> bit 45
    wr(12'h2D0, 32'h0000_1800);
    pin_in[180] = 1'b1; idle(4);
    rd(12'h2FC, d); check("R9 summary high word", d, 32'h0000_2000);
    wr(12'h2F8, 32'hFFFF_FFFF); wr(12'h2FC, 32'hFFFF_FFFF);
    rd(12'h2FC, d); check("R9 summary ignores writes high", d, 32'h0000_2000);
    rd(12'h2F8, d); check("R9 summary ignores writes low", d, 32'h0);

    // R10 end-of-interrupt while still pending
    check("R10 irq pending before eoi", 32'(host_irq), 32'd1);
    wr(12'h0FC, 32'h2000_0000);
    check("R10 eoi forces irq low", 32'(host_irq), 32'd0);
    idle(1);
    check("R10 irq re-evaluates after eoi", 32'(host_irq), 32'd1);
    rd(12'h0FC, d); check("R10 master reads zero", d, 32'h0);
    wr(12'h2D0, 32'h1000_1800); idle(2);
    check("R10 irq low after service", 32'(host_irq), 32'd0);

    // R11 shared word never reaches pin 63
    wr(12'h0FC, 32'h00C0_1900);
    pin_in[63] = 1'b1; idle(4);
    check("R11 pin63 not driven", 32'(pin_oe[63]), 32'd0);
    check("R11 pin63 raises nothing", 32'(host_irq), 32'd0);
    rd(12'h2F8, d); check("R11 group 15 quiet", d, 32'h0);
    rd(12'h0FC, d); check("R11 shared word reads zero", d, 32'h0);
    rd(12'h400, d); check("R11 unmapped reads zero", d, 32'h0);

    // R7 edge event and acknowledge in the same cycle on pin 20
    wr(12'h050, 32'h0000_1800);
    pin_in[20] = 1'b1; idle(4);
    pin_in[20] = 1'b0; idle(4);
    pin_in[20] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(12'h050, 32'h1000_1800);
    rd(12'h050, d); check("R7 edge beats same-cycle clear", d, 32'h1001_1800);
    wr(12'h050, 32'h1000_1800);
    rd(12'h050, d); check("R7 later clear takes effect", d, 32'h0001_1800);

    idle(4);
    finish_run();
  end
endmodule